// File: doc/BRIEF.md
# Special Register Write Controller

This block executes the move-to-special-register operation of a processor core. Each cycle it may receive one decoded write request: a 5-bit destination code, a 32-bit data word and a flag that marks the extended (upper-half) form. The block decides whether the destination may be written in the current build. Legal writes are committed to its bank of special registers. Illegal writes are rejected with a single-cycle error pulse.

The status register is held back one extra cycle before it takes effect. Its interrupt-enable, break-in-progress and exception-in-progress bits drive the accept and block outputs that gate incoming interrupt and break requests. When the build has a wide physical address, the translation-low register is loaded in two steps. An extended write delivers the upper bits first, and the next normal write to the same register delivers the lower bits.

Top module: `spr_write_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no write yet made, every register output is zero, `err_o` is low, `irq_accept_o` is low and `irq_block_o` is high.
- R2: Destination codes are as follows. 0 is status, 6 is floating-point status, 7 is stack low limit, 8 is stack high limit, 9 is process id, 10 is zone protection, 11 is translation low, 12 is translation high, 13 is translation index and 14 is translation search. Codes 1 to 5 (program counter, exception status, exception address, branch target, exception data) and 16 to 28 (version registers 0 to 12) are write-protected. Codes 15 and 29 to 31 are undefined. Writes to protected or undefined codes are rejected.
- R3: A legal status write sampled at clock edge N leaves `status_o` unchanged after edge N and shows the new value after edge N+1.
- R4: Code 6 is writable only when `FPU_LEVEL` > 0.
- R5: Codes 7 and 8 are writable only when `STACK_PROT` == 1.
- R6: Codes 9, 10 and 14 are writable only when `MMU_LEVEL` > 1 and `TLB_ACCESS` > 1.
- R7: Codes 12 and 13 are writable whenever `MMU_LEVEL` > 1. Code 11 is also writable by a normal write under that condition when the extended form is unavailable.
- R8: A rejected request raises `err_o` for exactly the one cycle after the edge that sampled it, and leaves every register output unchanged. A legal request never raises `err_o`.
- R9: `irq_accept_o` = `irq_in` AND status bit 0 (interrupt enable) AND NOT bit 1 (break in progress) AND NOT bit 2 (exception in progress). `irq_block_o` is its inverse gate, taken without `irq_in`.
- R10: `brk_accept_o` = `brk_in` AND NOT status bit 1 AND NOT status bit 2. `brk_block_o` is high while either bit is set.
- R11: An extended write (`wr_ext` = 1) is legal only to code 11, and only when `MMU_LEVEL` == 3 and `ADDR_BITS` > 32. It changes no output and holds its low `ADDR_BITS`-32 data bits. The next write request, if it is a normal write to code 11, commits the held bits to `tlb_lo_hi_o` and its data to `tlb_lo_o`.
- R12: When the extended form is available, a normal write to code 11 with no held upper half is rejected. Any write request other than the completing one discards the held half. Idle cycles keep it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present this cycle |
| wr_sel | input | 5 | Destination code |
| wr_data | input | 32 | Write data |
| wr_ext | input | 1 | Extended (upper-half) form |
| irq_in | input | 1 | Pending interrupt request |
| brk_in | input | 1 | Pending normal hardware break |
| status_o | output | 32 | Status register |
| fp_stat_o | output | 32 | Floating-point status |
| stk_lo_o | output | 32 | Stack low limit |
| stk_hi_o | output | 32 | Stack high limit |
| pid_o | output | 32 | Process id |
| zone_o | output | 32 | Zone protection |
| tlb_lo_o | output | 32 | Translation low, lower word |
| tlb_lo_hi_o | output | max(ADDR_BITS-32,1) | Translation low, upper bits |
| tlb_hi_o | output | 32 | Translation high |
| tlb_idx_o | output | 32 | Translation index |
| tlb_srch_o | output | 32 | Translation search |
| err_o | output | 1 | Rejected-write pulse |
| irq_accept_o | output | 1 | Interrupt accepted |
| brk_accept_o | output | 1 | Break accepted |
| irq_block_o | output | 1 | Interrupts suppressed |
| brk_block_o | output | 1 | Breaks suppressed |

## Verification
The error pulse and all non-status registers are due one edge after the request is sampled. The status register and the accept and block gates are due two edges after it. Inputs change on falling edges. Every step checks the error flag, every register and the gates at the first falling edge after the request, where status must still hold its old value. It then checks them again at the next falling edge, where status and the gates must show the new value and the error flag must have dropped. Three builds run side by side on the same stimulus, so each legality rule is seen both enabled and disabled for every code and both write forms.

// File: rtl/spr_write_ctrl.sv
module spr_write_ctrl #(
  parameter int FPU_LEVEL  = 1,
  parameter int STACK_PROT = 1,
  parameter int MMU_LEVEL  = 3,
  parameter int TLB_ACCESS = 2,
  parameter int ADDR_BITS  = 40,
  localparam int UPW = (ADDR_BITS > 32) ? ADDR_BITS - 32 : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_valid,
  input  logic [4:0]     wr_sel,
  input  logic [31:0]    wr_data,
  input  logic           wr_ext,
  input  logic           irq_in,
  input  logic           brk_in,
  output logic [31:0]    status_o,
  output logic [31:0]    fp_stat_o,
  output logic [31:0]    stk_lo_o,
  output logic [31:0]    stk_hi_o,
  output logic [31:0]    pid_o,
  output logic [31:0]    zone_o,
  output logic [31:0]    tlb_lo_o,
  output logic [UPW-1:0] tlb_lo_hi_o,
  output logic [31:0]    tlb_hi_o,
  output logic [31:0]    tlb_idx_o,
  output logic [31:0]    tlb_srch_o,
  output logic           err_o,
  output logic           irq_accept_o,
  output logic           brk_accept_o,
  output logic           irq_block_o,
  output logic           brk_block_o
);

  localparam logic [4:0] S_STAT = 5'd0,  S_PC   = 5'd1,  S_FPS  = 5'd6,
                         S_SLO  = 5'd7,  S_SHI  = 5'd8,  S_PID  = 5'd9,
                         S_ZONE = 5'd10, S_TLO  = 5'd11, S_THI  = 5'd12,
                         S_TIDX = 5'd13, S_TSR  = 5'd14, S_VER0 = 5'd16,
                         S_VERN = 5'd28;
  localparam bit HAS_FPS  = FPU_LEVEL > 0;
  localparam bit HAS_STK  = STACK_PROT == 1;
  localparam bit HAS_TLB  = MMU_LEVEL > 1;
  localparam bit HAS_TACC = HAS_TLB && (TLB_ACCESS > 1);
  localparam bit EXT_OK   = (MMU_LEVEL == 3) && (ADDR_BITS > 32);

  logic           base_ok, wr_ok, commit;
  logic           stage_v, pend_v;
  logic [31:0]    stage_d;
  logic [UPW-1:0] pend_d;

  always_comb begin
    case (wr_sel)
      S_STAT:               base_ok = 1'b1;
      S_FPS:                base_ok = HAS_FPS;
      S_SLO, S_SHI:         base_ok = HAS_STK;
      S_PID, S_ZONE, S_TSR: base_ok = HAS_TACC;
      S_TLO:                base_ok = HAS_TLB && (!EXT_OK || wr_ext || pend_v);
      S_THI, S_TIDX:        base_ok = HAS_TLB;
      default:              base_ok = 1'b0;
    endcase
  end

  assign wr_ok  = base_ok && (!wr_ext || (wr_sel == S_TLO && EXT_OK));
  assign commit = wr_valid && wr_ok && !wr_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o <= 1'b0;  stage_v <= 1'b0;  stage_d <= '0;
      pend_v <= 1'b0; pend_d <= '0;     status_o <= '0;
      fp_stat_o <= '0; stk_lo_o <= '0;  stk_hi_o <= '0;
      pid_o <= '0;    zone_o <= '0;     tlb_lo_o <= '0;
      tlb_lo_hi_o <= '0; tlb_hi_o <= '0; tlb_idx_o <= '0;
      tlb_srch_o <= '0;
    end else begin
      err_o   <= wr_valid && !wr_ok;
      stage_v <= commit && (wr_sel == S_STAT);
      stage_d <= wr_data;
      if (stage_v) status_o <= stage_d;
      if (wr_valid) begin
        pend_v <= wr_ok && wr_ext;
        if (wr_ext) pend_d <= wr_data[UPW-1:0];
      end
      if (commit) begin
        case (wr_sel)
          S_FPS:  fp_stat_o  <= wr_data;
          S_SLO:  stk_lo_o   <= wr_data;
          S_SHI:  stk_hi_o   <= wr_data;
          S_PID:  pid_o      <= wr_data;
          S_ZONE: zone_o     <= wr_data;
          S_TLO: begin
            tlb_lo_o <= wr_data;
            if (EXT_OK) tlb_lo_hi_o <= pend_d;
          end
          S_THI:  tlb_hi_o   <= wr_data;
          S_TIDX: tlb_idx_o  <= wr_data;
          S_TSR:  tlb_srch_o <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign brk_block_o  = status_o[1] | status_o[2];
  assign irq_block_o  = ~status_o[0] | brk_block_o;
  assign irq_accept_o = irq_in & ~irq_block_o;
  assign brk_accept_o = brk_in & ~brk_block_o;

  // R3
  stat_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != $past(status_o)) |-> $past(wr_valid && wr_sel == S_STAT && !wr_ext, 2));

  // R9
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid && wr_sel == S_STAT && !wr_ext && !wr_data[0], 2) |-> !irq_accept_o);

  // R10
  hold_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid && wr_sel == S_STAT && !wr_ext && (wr_data[1] || wr_data[2]), 2)
      |-> (!brk_accept_o && !irq_accept_o));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(wr_valid));

  // R2
  prot_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ((wr_sel >= S_PC && wr_sel < S_FPS) || (wr_sel >= S_VER0 && wr_sel <= S_VERN)))
      |=> err_o);

  // R11
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ext) |=> ($stable(tlb_lo_o) && $stable(tlb_lo_hi_o)));

endmodule

// File: tb/spr_write_ctrl_bench.sv
module spr_write_ctrl_bench;
  localparam int NC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ext = 1'b0, irq_in = 1'b1, brk_in = 1'b1;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  always #2.5 clk = ~clk;

  logic [31:0] o_st[NC], o_fp[NC], o_slo[NC], o_shi[NC], o_pid[NC], o_zone[NC];
  logic [31:0] o_tlo[NC], o_thi[NC], o_tidx[NC], o_tsr[NC];
  logic [7:0]  o_hi0;
  logic        o_hi1, o_hi2;
  logic        o_err[NC], o_ia[NC], o_ba[NC], o_ib[NC], o_bb[NC];

  spr_write_ctrl #(.FPU_LEVEL(1), .STACK_PROT(1), .MMU_LEVEL(3), .TLB_ACCESS(2), .ADDR_BITS(40))
  u_spr_write_ctrl (.clk, .rst_n, .wr_valid, .wr_sel, .wr_data, .wr_ext, .irq_in, .brk_in,
    .status_o(o_st[0]), .fp_stat_o(o_fp[0]), .stk_lo_o(o_slo[0]), .stk_hi_o(o_shi[0]),
    .pid_o(o_pid[0]), .zone_o(o_zone[0]), .tlb_lo_o(o_tlo[0]), .tlb_lo_hi_o(o_hi0),
    .tlb_hi_o(o_thi[0]), .tlb_idx_o(o_tidx[0]), .tlb_srch_o(o_tsr[0]), .err_o(o_err[0]),
    .irq_accept_o(o_ia[0]), .brk_accept_o(o_ba[0]), .irq_block_o(o_ib[0]), .brk_block_o(o_bb[0]));

  spr_write_ctrl #(.FPU_LEVEL(0), .STACK_PROT(0), .MMU_LEVEL(0), .TLB_ACCESS(0), .ADDR_BITS(32))
  u_spr_write_ctrl_min (.clk, .rst_n, .wr_valid, .wr_sel, .wr_data, .wr_ext, .irq_in, .brk_in,
    .status_o(o_st[1]), .fp_stat_o(o_fp[1]), .stk_lo_o(o_slo[1]), .stk_hi_o(o_shi[1]),
    .pid_o(o_pid[1]), .zone_o(o_zone[1]), .tlb_lo_o(o_tlo[1]), .tlb_lo_hi_o(o_hi1),
    .tlb_hi_o(o_thi[1]), .tlb_idx_o(o_tidx[1]), .tlb_srch_o(o_tsr[1]), .err_o(o_err[1]),
    .irq_accept_o(o_ia[1]), .brk_accept_o(o_ba[1]), .irq_block_o(o_ib[1]), .brk_block_o(o_bb[1]));

  spr_write_ctrl #(.FPU_LEVEL(2), .STACK_PROT(0), .MMU_LEVEL(2), .TLB_ACCESS(1), .ADDR_BITS(32))
  u_spr_write_ctrl_mid (.clk, .rst_n, .wr_valid, .wr_sel, .wr_data, .wr_ext, .irq_in, .brk_in,
    .status_o(o_st[2]), .fp_stat_o(o_fp[2]), .stk_lo_o(o_slo[2]), .stk_hi_o(o_shi[2]),
    .pid_o(o_pid[2]), .zone_o(o_zone[2]), .tlb_lo_o(o_tlo[2]), .tlb_lo_hi_o(o_hi2),
    .tlb_hi_o(o_thi[2]), .tlb_idx_o(o_tidx[2]), .tlb_srch_o(o_tsr[2]), .err_o(o_err[2]),
    .irq_accept_o(o_ia[2]), .brk_accept_o(o_ba[2]), .irq_block_o(o_ib[2]), .brk_block_o(o_bb[2]));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] m[NC][32];
  logic [7:0]  mhi[NC], pd[NC];
  bit          pend[NC];

  function automatic int p_fpu(int c); return c == 0 ? 1 : (c == 2 ? 2 : 0); endfunction
  function automatic int p_stk(int c); return c == 0 ? 1 : 0; endfunction
  function automatic int p_mmu(int c); return c == 0 ? 3 : (c == 2 ? 2 : 0); endfunction
  function automatic int p_tac(int c); return c == 0 ? 2 : (c == 2 ? 1 : 0); endfunction
  function automatic int p_ab(int c);  return c == 0 ? 40 : 32; endfunction
  function automatic bit ext_ok(int c); return p_mmu(c) == 3 && p_ab(c) > 32; endfunction

  function automatic bit ok_fn(int c, int s, bit e);
    bit b;
    case (s)
      0:         b = 1'b1;
      6:         b = p_fpu(c) > 0;
      7, 8:      b = p_stk(c) == 1;
      9, 10, 14: b = p_mmu(c) > 1 && p_tac(c) > 1;
      11:        b = p_mmu(c) > 1 && (!ext_ok(c) || e || pend[c]);
      12, 13:    b = p_mmu(c) > 1;
      default:   b = 1'b0;
    endcase
    if (e && !(s == 11 && ext_ok(c))) b = 1'b0;
    return b;
  endfunction

  function automatic string tag_for(int s, bit e);
    if (e) return "R11";
    case (s)
      0: return "R3";
      6: return "R4";
      7, 8: return "R5";
      9, 10, 14: return "R6";
      11: return "R12";
      12, 13: return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [31:0] out_of(int c, int s);
    case (s)
      0: return o_st[c];   6: return o_fp[c];   7: return o_slo[c];
      8: return o_shi[c];  9: return o_pid[c];  10: return o_zone[c];
      11: return o_tlo[c]; 12: return o_thi[c]; 13: return o_tidx[c];
      14: return o_tsr[c];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] hi_of(int c);
    return c == 0 ? o_hi0 : {7'b0, (c == 1 ? o_hi1 : o_hi2)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(int c, string tag);
    for (int s = 6; s <= 14; s++) chk(tag, out_of(c, s), m[c][s]);
    chk(tag, {24'b0, hi_of(c)}, {24'b0, mhi[c]});
  endtask

  task automatic chk_gates(int c);
    logic [31:0] st = m[c][0];
    chk("R3", o_st[c], st);
    chk("R9", {31'b0, o_ia[c]}, {31'b0, irq_in & st[0] & ~st[1] & ~st[2]});
    chk("R9", {31'b0, o_ib[c]}, {31'b0, ~st[0] | st[1] | st[2]});
    chk("R10", {31'b0, o_ba[c]}, {31'b0, brk_in & ~st[1] & ~st[2]});
    chk("R10", {31'b0, o_bb[c]}, {31'b0, st[1] | st[2]});
  endtask

  task automatic step(int s, logic [31:0] d, bit e);
    bit okv[NC];
    for (int c = 0; c < NC; c++) okv[c] = ok_fn(c, s, e);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = 5'(s); wr_data = d; wr_ext = e;
    @(negedge clk);
    wr_valid = 1'b0; wr_ext = 1'b0;
    for (int c = 0; c < NC; c++) begin
      if (okv[c] && !e && s != 0) m[c][s] = d;
      if (okv[c] && !e && s == 11 && ext_ok(c)) mhi[c] = pd[c];
      pend[c] = okv[c] && e;
      if (e) pd[c] = d[7:0];
      chk(tag_for(s, e), {31'b0, o_err[c]}, {31'b0, !okv[c]});
      chk_regs(c, "R8");
      chk_gates(c);
    end
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      if (okv[c] && !e && s == 0) m[c][0] = d;
      chk("R8", {31'b0, o_err[c]}, 32'h0);
      chk_regs(c, "R8");
      chk_gates(c);
    end
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      for (int s = 0; s < 32; s++) m[c][s] = '0;
      mhi[c] = '0; pd[c] = '0; pend[c] = 1'b0;
    end
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk("R1", {31'b0, o_err[c]}, 32'h0);
      chk_regs(c, "R1");
      chk("R1", o_st[c], 32'h0);
      chk("R1", {31'b0, o_ia[c]}, 32'h0);
      chk("R1", {31'b0, o_ib[c]}, 32'h1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk_regs(c, "R1");
      chk_gates(c);
    end
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 32; s++)
        step(s, 32'hC3A5_0000 ^ (s * 32'h0001_0203) ^ (e != 0 ? 32'hFF : 32'h0), e != 0);
    step(0, 32'h1, 1'b0);
    step(0, 32'h5, 1'b0);
    step(0, 32'h1, 1'b0);
    step(0, 32'h3, 1'b0);
    step(0, 32'h1, 1'b0);
    step(0, 32'h0, 1'b0);
    step(0, 32'h1, 1'b0);
    step(11, 32'h0000_00AB, 1'b1);
    step(11, 32'h1234_5678, 1'b0);
    step(11, 32'h0000_0077, 1'b1);
    step(9, 32'h0000_9999, 1'b0);
    step(11, 32'h4444_4444, 1'b0);
    step(11, 32'h0000_00CD, 1'b1);
    step(12, 32'h0000_0001, 1'b1);
    step(11, 32'h5555_5555, 1'b0);
    step(11, 32'h0000_0011, 1'b1);
    step(11, 32'h6666_6666, 1'b0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule